// File: doc/BRIEF.md
# Reset-Addressed Dual-Lane Field Delay Memory

This block is a serial field store made of byte-wide lanes that share one write clock and one read clock, with the two clocks fully unrelated. Each lane has its own write and read pointers. The pointers are not managed by occupancy. An external clear pulse on either side returns a pointer to location zero. The delay between a byte going in and the same byte coming out is therefore fixed by when the two clears are issued relative to each other. There are no full or empty indications.

Each side of each lane has two enables. A step enable, when low, freezes the pointer. A data enable leaves the pointer advancing. On the write side the data enable masks the store, so only chosen regions of a stored picture are overwritten. On the read side it switches the lane's output to a disabled state, signalled by a per-lane drive flag with the data held at zero. Because the lanes share clocks, driving both lanes with the same controls makes them act as one 16-bit store.

A sticky flag reports any read step taken while the read address is closer than `MIN_LAG` locations behind the write pointer, as the write pointer is seen after synchronisation into the read domain. `DEPTH` must be a power of two and `MIN_LAG` must be smaller than `DEPTH`.

Top module: `field_delay_mem`

## Requirements
- R1: On a write-clock edge where a lane's write-clear bit is high, that edge addresses location 0. If the step bit is also high, the byte is stored at 0 and the next edge addresses 1.
- R2: On a write-clock edge where a lane's write-step bit is low, nothing is stored and that lane's write pointer holds.
- R3: On a write-clock edge with step high and write-data-enable low, the addressed location keeps its old contents while the write pointer still advances by one.
- R4: On a read-clock edge where a lane's read-clear bit is high, location 0 is read on that same edge. Its word is on the outputs right after that edge, with no added latency.
- R5: On a read-clock edge where a lane's read-step bit is low, the read pointer and that lane's output word both hold.
- R6: After a read-clock edge with that lane's output-enable bit low, its drive flag is 0 and its data bits are 0. The read pointer still advances on that edge, so the next enabled read returns the following location.
- R7: Both pointers wrap from location DEPTH-1 to location 0.
- R8: Lane l uses bits [8l+7:8l] of the wide data buses and bit l of every control and drive vector. The lanes' controls act independently of each other.
- R9: `lag_err_o` goes to 1 after a read-clock edge that steps a lane while (synchronised write pointer − read address) mod DEPTH is below MIN_LAG. Once set, it stays 1 until reset.
- R10: While reset is asserted, all drive flags are 0, all data outputs are 0 and `lag_err_o` is 0. After reset both pointers of every lane are at 0.
- R11: Read data is registered. A word appears after the read-clock edge that addresses it, and the drive flag reflects the output-enable bit sampled on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously in each clock domain |
| wclk_i | input | 1 | Write clock shared by all lanes |
| wr_clr_i | input | LANES | Per-lane write pointer clear |
| wr_adv_i | input | LANES | Per-lane write step enable (low freezes the pointer) |
| wr_den_i | input | LANES | Per-lane write data enable (low masks the store) |
| wr_data_i | input | LANES*DATA_W | Input bytes, lane l in bits [8l+7:8l] |
| rclk_i | input | 1 | Read clock shared by all lanes |
| rd_clr_i | input | LANES | Per-lane read pointer clear |
| rd_adv_i | input | LANES | Per-lane read step enable (low freezes pointer and word) |
| rd_oe_i | input | LANES | Per-lane output enable (low disables the lane's output) |
| rd_data_o | output | LANES*DATA_W | Output bytes, zero for a disabled lane |
| rd_drive_o | output | LANES | Per-lane drive flag, 1 when the lane's output is enabled |
| lag_err_o | output | 1 | Sticky flag for a read step taken below the minimum lag |

## Verification
A write is observable only through a later read, so every write-side rule is checked by reading the affected locations back. Read data, the drive flag and the lag flag all change on the read-clock rising edge that samples the controls. The bench sets the controls at a falling edge, lets one rising edge pass, and compares at the next falling edge. Each check is therefore tied to exactly the edge whose controls it judges. The write pointer reaches the lag monitor only after two synchroniser stages, so lag checks start only after the writes have stopped for many read cycles. Expected words are computed from per-phase formulas of the address.

// File: rtl/fdm_pkg.sv
package fdm_pkg;

  // Per-lane write-side controls sampled on the write clock.
  typedef struct packed {
    logic clr;   // pointer clear
    logic adv;   // step enable
    logic den;   // data (store) enable
  } wr_ctl_t;

  // Per-lane read-side controls sampled on the read clock.
  typedef struct packed {
    logic clr;   // pointer clear
    logic adv;   // step enable
    logic oe;    // output enable
  } rd_ctl_t;

endpackage

// File: rtl/fdm_rst_sync.sv
module fdm_rst_sync (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);

  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];

endmodule

// File: rtl/fdm_lane.sv
module fdm_lane
  import fdm_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              wclk_i,
  input  logic              wrst_ni,
  input  wr_ctl_t           wctl_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [AW-1:0]     wptr_gray_o,
  input  logic              rclk_i,
  input  logic              rrst_ni,
  input  rd_ctl_t           rctl_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rdrive_o,
  output logic [AW-1:0]     raddr_o,
  output logic              rstep_o
);

  logic [DATA_W-1:0] mem [DEPTH];

  // ---------------- write side ----------------
  logic [AW-1:0] wptr_q, wptr_d, waddr;
  logic [AW-1:0] wgray_q, wgray_d;
  logic          wr_store;

  always_comb begin
    waddr    = wctl_i.clr ? '0 : wptr_q;
    wptr_d   = wctl_i.adv ? waddr + AW'(1) : waddr;
    wr_store = wctl_i.adv & wctl_i.den;
    wgray_d  = wptr_d ^ (wptr_d >> 1);
  end

  always_ff @(posedge wclk_i or negedge wrst_ni) begin
    if (!wrst_ni) begin
      wptr_q  <= '0;
      wgray_q <= '0;
    end else begin
      wptr_q  <= wptr_d;
      wgray_q <= wgray_d;
    end
  end

  always_ff @(posedge wclk_i) begin
    if (wr_store) mem[waddr] <= wdata_i;
  end

  assign wptr_gray_o = wgray_q;

  // ---------------- read side ----------------
  logic [AW-1:0]     rptr_q, rptr_d, raddr;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              rdrive_q;

  always_comb begin
    raddr   = rctl_i.clr ? '0 : rptr_q;
    rptr_d  = rctl_i.adv ? raddr + AW'(1) : raddr;
    rdata_d = rctl_i.adv ? mem[raddr] : rdata_q;
  end

  always_ff @(posedge rclk_i or negedge rrst_ni) begin
    if (!rrst_ni) begin
      rptr_q   <= '0;
      rdata_q  <= '0;
      rdrive_q <= 1'b0;
    end else begin
      rptr_q   <= rptr_d;
      rdata_q  <= rdata_d;
      rdrive_q <= rctl_i.oe;
    end
  end

  assign rdata_o  = rdrive_q ? rdata_q : '0;
  assign rdrive_o = rdrive_q;
  assign raddr_o  = raddr;
  assign rstep_o  = rctl_i.adv;

  // ---------------- assertions ----------------
  p_wclr_restart_r1: assert property (@(posedge wclk_i) disable iff (!wrst_ni)
    wctl_i.clr |=> (wptr_q == ($past(wctl_i.adv) ? AW'(1) : AW'(0))));

  p_whold_r2: assert property (@(posedge wclk_i) disable iff (!wrst_ni)
    (!wctl_i.clr && !wctl_i.adv) |=> $stable(wptr_q));

  p_wmask_steps_r3: assert property (@(posedge wclk_i) disable iff (!wrst_ni)
    (!wctl_i.clr && wctl_i.adv && !wctl_i.den) |=> (wptr_q == $past(wptr_q) + AW'(1)));

  p_rclr_restart_r4: assert property (@(posedge rclk_i) disable iff (!rrst_ni)
    rctl_i.clr |=> (rptr_q == ($past(rctl_i.adv) ? AW'(1) : AW'(0))));

  p_rhold_r5: assert property (@(posedge rclk_i) disable iff (!rrst_ni)
    (!rctl_i.clr && !rctl_i.adv) |=> ($stable(rptr_q) && $stable(rdata_q)));

  p_oe_off_r6: assert property (@(posedge rclk_i) disable iff (!rrst_ni)
    !rctl_i.oe |=> (!rdrive_o && (rdata_o == '0)));

  p_wwrap_r7: assert property (@(posedge wclk_i) disable iff (!wrst_ni)
    (!wctl_i.clr && wctl_i.adv && wptr_q == AW'(DEPTH - 1)) |=> (wptr_q == '0));

  p_rwrap_r7: assert property (@(posedge rclk_i) disable iff (!rrst_ni)
    (!rctl_i.clr && rctl_i.adv && rptr_q == AW'(DEPTH - 1)) |=> (rptr_q == '0));

endmodule

// File: rtl/fdm_lag_mon.sv
module fdm_lag_mon #(
  parameter int DEPTH   = 64,
  parameter int MIN_LAG = 8,
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic          rclk_i,
  input  logic          rrst_ni,
  input  logic [AW-1:0] wgray_i,
  input  logic [AW-1:0] raddr_i,
  input  logic          rstep_i,
  output logic          viol_o
);

  logic [AW-1:0] s1_q, s2_q;
  logic [AW-1:0] wbin, lag;

  // Two-stage synchroniser for the Gray-coded write pointer.
  always_ff @(posedge rclk_i or negedge rrst_ni) begin
    if (!rrst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= wgray_i;
      s2_q <= s1_q;
    end
  end

  always_comb begin
    for (int i = 0; i < AW; i++) wbin[i] = ^(s2_q >> i);
    lag    = wbin - raddr_i;
    viol_o = rstep_i && (lag < AW'(MIN_LAG));
  end

endmodule

// File: rtl/field_delay_mem.sv
module field_delay_mem
  import fdm_pkg::*;
#(
  parameter int LANES   = 2,
  parameter int DATA_W  = 8,
  parameter int DEPTH   = 64,
  parameter int MIN_LAG = 8
) (
  input  logic                    rst_ni,
  input  logic                    wclk_i,
  input  logic [LANES-1:0]        wr_clr_i,
  input  logic [LANES-1:0]        wr_adv_i,
  input  logic [LANES-1:0]        wr_den_i,
  input  logic [LANES*DATA_W-1:0] wr_data_i,
  input  logic                    rclk_i,
  input  logic [LANES-1:0]        rd_clr_i,
  input  logic [LANES-1:0]        rd_adv_i,
  input  logic [LANES-1:0]        rd_oe_i,
  output logic [LANES*DATA_W-1:0] rd_data_o,
  output logic [LANES-1:0]        rd_drive_o,
  output logic                    lag_err_o
);

  localparam int AW = $clog2(DEPTH);

  logic wrst_n, rrst_n;

  fdm_rst_sync u_wrst (.clk_i(wclk_i), .arst_ni(rst_ni), .rst_no(wrst_n));
  fdm_rst_sync u_rrst (.clk_i(rclk_i), .arst_ni(rst_ni), .rst_no(rrst_n));

  logic [LANES-1:0] viol;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    wr_ctl_t       wctl;
    rd_ctl_t       rctl;
    logic [AW-1:0] wgray, raddr;
    logic          rstep;

    assign wctl = '{clr: wr_clr_i[l], adv: wr_adv_i[l], den: wr_den_i[l]};
    assign rctl = '{clr: rd_clr_i[l], adv: rd_adv_i[l], oe: rd_oe_i[l]};

    fdm_lane #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_lane (
      .wclk_i     (wclk_i),
      .wrst_ni    (wrst_n),
      .wctl_i     (wctl),
      .wdata_i    (wr_data_i[l*DATA_W +: DATA_W]),
      .wptr_gray_o(wgray),
      .rclk_i     (rclk_i),
      .rrst_ni    (rrst_n),
      .rctl_i     (rctl),
      .rdata_o    (rd_data_o[l*DATA_W +: DATA_W]),
      .rdrive_o   (rd_drive_o[l]),
      .raddr_o    (raddr),
      .rstep_o    (rstep)
    );

    fdm_lag_mon #(.DEPTH(DEPTH), .MIN_LAG(MIN_LAG)) u_lag (
      .rclk_i (rclk_i),
      .rrst_ni(rrst_n),
      .wgray_i(wgray),
      .raddr_i(raddr),
      .rstep_i(rstep),
      .viol_o (viol[l])
    );
  end

  // Sticky lag flag (R9).
  logic err_q, err_d;

  always_comb err_d = err_q | (|viol);

  always_ff @(posedge rclk_i or negedge rrst_n) begin
    if (!rrst_n) err_q <= 1'b0;
    else         err_q <= err_d;
  end

  assign lag_err_o = err_q;

  p_err_sticky_r9: assert property (@(posedge rclk_i) disable iff (!rrst_n)
    lag_err_o |=> lag_err_o);

  p_reset_quiet_r10: assert property (@(posedge rclk_i)
    !rrst_n |-> (rd_drive_o == '0 && !lag_err_o));

endmodule

// File: tb/field_delay_mem_test.sv
module field_delay_mem_test;

  localparam int CLK_PERIOD  = 10;
  localparam int RCLK_PERIOD = 14;
  localparam int DEPTH       = 64;
  localparam int MIN_LAG     = 8;

  logic        rst_n, wclk, rclk;
  logic [1:0]  wr_clr, wr_adv, wr_den, rd_clr, rd_adv, rd_oe;
  logic [15:0] wr_data;
  logic [15:0] rd_data;
  logic [1:0]  rd_drive;
  logic        lag_err;

  int checks;
  int failures;
  bit done;

  field_delay_mem #(.LANES(2), .DATA_W(8), .DEPTH(DEPTH), .MIN_LAG(MIN_LAG)) uut (
    .rst_ni(rst_n), .wclk_i(wclk), .wr_clr_i(wr_clr), .wr_adv_i(wr_adv),
    .wr_den_i(wr_den), .wr_data_i(wr_data), .rclk_i(rclk), .rd_clr_i(rd_clr),
    .rd_adv_i(rd_adv), .rd_oe_i(rd_oe), .rd_data_o(rd_data),
    .rd_drive_o(rd_drive), .lag_err_o(lag_err)
  );

  initial wclk = 1'b0;
  always #(CLK_PERIOD / 2) wclk = ~wclk;
  initial rclk = 1'b0;
  always #(RCLK_PERIOD / 2) rclk = ~rclk;

  // Data patterns per phase, as functions of address.
  function automatic logic [7:0] f0(int i); return 8'(3 * i + 1);     endfunction
  function automatic logic [7:0] f1(int i); return 8'(8'hA0 + i);     endfunction
  function automatic logic [7:0] g0(int i); return 8'(8'h40 + 7 * i); endfunction
  function automatic logic [7:0] g1(int i); return 8'(8'hC3 - i);     endfunction
  function automatic logic [7:0] h0(int i); return 8'(i) ^ 8'h55;     endfunction
  function automatic logic [7:0] h1(int i); return 8'(2 * i + 9);     endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Inputs are set at a falling edge; one rising edge then samples them.
  task automatic wr_edge(input logic [1:0] clr, input logic [1:0] adv,
                         input logic [1:0] den, input logic [7:0] d0, input logic [7:0] d1);
    wr_clr = clr; wr_adv = adv; wr_den = den; wr_data = {d1, d0};
    @(posedge wclk);
    @(negedge wclk);
  endtask

  task automatic rd_edge(input logic [1:0] clr, input logic [1:0] adv, input logic [1:0] oe);
    rd_clr = clr; rd_adv = adv; rd_oe = oe;
    @(posedge rclk);
    @(negedge rclk);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge wclk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    checks = 0; failures = 0; done = 1'b0;
    rst_n = 1'b0;
    wr_clr = '0; wr_adv = '0; wr_den = '0; wr_data = '0;
    rd_clr = '0; rd_adv = '0; rd_oe = '0;
    repeat (4) @(negedge rclk);
    // R10: quiet outputs during reset
    chk("R10 drive in reset", 32'(rd_drive), 32'h0);
    chk("R10 data in reset", 32'(rd_data), 32'h0);
    chk("R10 lag flag in reset", 32'(lag_err), 32'h0);
    rst_n = 1'b1;
    repeat (6) @(posedge wclk);
    repeat (6) @(posedge rclk);

    // Phase A: fill 48 locations in both lanes.
    @(negedge wclk);
    for (int i = 0; i < 48; i++)
      wr_edge((i == 0) ? 2'b11 : 2'b00, 2'b11, 2'b11, f0(i), f1(i));
    wr_edge(2'b00, 2'b00, 2'b00, 8'h00, 8'h00);

    // Phase B: lane0 masks 10..19 (R3); lane1 freezes on 5..7 (R2).
    for (int k = 0; k < 51; k++) begin
      logic a1, d0b;
      int   addr1;
      a1    = !(k >= 5 && k <= 7);
      d0b   = !(k >= 10 && k <= 19);
      addr1 = (k < 5) ? k : k - 3;
      wr_edge((k == 0) ? 2'b11 : 2'b00, {a1, 1'b1}, {1'b1, d0b},
              g0(k), a1 ? g1(addr1) : 8'hEE);
    end
    wr_edge(2'b00, 2'b00, 2'b00, 8'h00, 8'h00);
    repeat (8) @(posedge rclk);

    // Phase R: read back; lane0 output off at 20..22 (R6), lane1 steps off at 25,26 (R5).
    @(negedge rclk);
    for (int k = 0; k < 40; k++) begin
      logic oe0, adv1;
      int   a1;
      oe0  = !(k >= 20 && k <= 22);
      adv1 = !(k == 25 || k == 26);
      rd_edge((k == 0) ? 2'b11 : 2'b00, {adv1, 1'b1}, {1'b1, oe0});
      if (!oe0) begin
        chk("R6 lane0 drive off", 32'(rd_drive[0]), 32'h0);
        chk("R6 lane0 data zero", 32'(rd_data[7:0]), 32'h0);
      end else if (k == 0) begin
        chk("R4 lane0 first word", 32'(rd_data[7:0]), 32'(g0(0)));
      end else if (k >= 10 && k <= 19) begin
        chk("R3 lane0 masked keeps old", 32'(rd_data[7:0]), 32'(f0(k)));
      end else begin
        chk("R11 R6 lane0 word", 32'(rd_data[7:0]), 32'(g0(k)));
        chk("R11 lane0 drive on", 32'(rd_drive[0]), 32'h1);
      end
      a1 = (k <= 24) ? k : ((k <= 26) ? 24 : k - 2);
      if (k == 25 || k == 26)
        chk("R5 lane1 word held", 32'(rd_data[15:8]), 32'(g1(a1)));
      else
        chk("R2 R8 lane1 word", 32'(rd_data[15:8]), 32'(g1(a1)));
    end
    chk("R9 no lag flag at safe lag", 32'(lag_err), 32'h0);

    // Lag violation: lane0 at 40..44 against write pointer 51; lag 7 at 44.
    for (int k = 40; k < 45; k++) begin
      rd_edge(2'b00, 2'b01, 2'b01);
      chk("R9 lane0 word near writer", 32'(rd_data[7:0]), 32'(g0(k)));
      chk("R9 lag flag", 32'(lag_err), (k == 44) ? 32'h1 : 32'h0);
    end
    for (int k = 0; k < 3; k++) begin
      rd_edge(2'b00, 2'b00, 2'b00);
      chk("R9 lag flag sticky", 32'(lag_err), 32'h1);
    end

    // Wrap: 66 writes then 66 reads from a clear (R7).
    @(negedge wclk);
    for (int i = 0; i < 66; i++)
      wr_edge((i == 0) ? 2'b11 : 2'b00, 2'b11, 2'b11, h0(i), h1(i));
    wr_edge(2'b00, 2'b00, 2'b00, 8'h00, 8'h00);
    repeat (8) @(posedge rclk);
    @(negedge rclk);
    for (int k = 0; k < 66; k++) begin
      int a;
      a = k % DEPTH;
      rd_edge((k == 0) ? 2'b11 : 2'b00, 2'b11, 2'b11);
      if (a < 2) begin
        chk("R7 lane0 wrapped word", 32'(rd_data[7:0]), 32'(h0(a + DEPTH)));
        chk("R7 lane1 wrapped word", 32'(rd_data[15:8]), 32'(h1(a + DEPTH)));
      end else begin
        chk("R7 R1 lane0 word", 32'(rd_data[7:0]), 32'(h0(a)));
        chk("R7 R1 lane1 word", 32'(rd_data[15:8]), 32'(h1(a)));
      end
    end
    chk("R9 lag flag still set", 32'(lag_err), 32'h1);

    done = 1'b1;
    finish_run();
  end

endmodule